// File: doc/BRIEF.md
# Translation Buffer Control Register File

This block is the software-facing register set that maintains a translation buffer. Software reaches the buffer entries through an index register and two window registers. The high window maps onto a tag store. The low window maps onto a data store that is two words wide. A process-ID register, a zone-protection register and a write-only search register complete the set. Each entry also keeps a translation ID. A write to the high window copies that ID from the process-ID register, and a read of the high window copies it back.

Register accesses arrive as single-cycle requests carrying a 3-bit register code, a write flag and an extended-half flag. Read data is registered and is valid on the cycle after the request. A write to the search register starts a handshake with an external lookup engine. The control state machine has two states. It moves from `S_IDLE` to `S_WAIT` through the transition *launch*, taken when a permitted search write is accepted. It moves from `S_WAIT` back to `S_IDLE` through the transition *resolve*, taken when the engine returns `srch_done`. In `S_WAIT` the block reports busy and takes no other request. When the result returns, the index register is updated with either the matching entry or the miss flag.

Register codes are: 0 low window, 1 high window, 2 index, 3 process ID, 4 zone protection, 5 search. Codes 6 and 7 are unused. The access level `cfg_access` uses the following values. 0 means no access at all. Bit 0 grants reads of the windows, the process ID and the zone register. A value of 2 or more grants writes to the process ID, the zone register and the search register.

Top module: `tlbreg_top`

## Requirements
- R1: After reset, every register and entry is zero, `busy` and `srch_valid` are low, and `acc_rdata` is zero.
- R2: A write to the index register (code 2) updates bits 30:0 only. Bit 31 is a miss flag that software cannot write. Reading code 2 returns the full register. Entries are selected by the low log2(ENTRIES) bits of the register.
- R3: A non-extended write to code 1 stores the word in the selected tag entry and stores process-ID bits 7:0 as that entry's translation ID. A non-extended write to code 0 stores the lower data half of the selected entry.
- R4: A read of code 1 returns the selected tag word and loads the process-ID register with that entry's translation ID, zero-extended.
- R5: An extended access to code 0 reads or writes the upper data half. An extended access to any other code reads zero and writes nothing.
- R6: Writes to codes 3, 4 and 5 take effect only when `cfg_access` is 2 or 3.
- R7: Reads of codes 0, 1, 3 and 4 return zero and have no side effect unless `cfg_access` bit 0 is set.
- R8: When `cfg_mmu_on` is low or `cfg_access` is 0, every read returns zero and every write is ignored.
- R9: A permitted write to code 5 raises `busy` and `srch_valid` from the next cycle. It presents write-data bits 31:10 on `srch_page` and holds them until `srch_done`.
- R10: On the edge where `srch_done` is sampled high while busy, a hit loads the index register with `srch_index` and bit 31 clear. A miss sets bit 31 and leaves bits 30:0 unchanged. `busy` falls on that same edge.
- R11: Reads of code 5 and of codes 6 and 7 return zero. Writes to codes 6 and 7 change nothing.
- R12: While busy, every request is ignored and every read returns zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_mmu_on | input | 1 | Translation unit present |
| cfg_access | input | 2 | Software access level |
| acc_valid | input | 1 | Register request strobe |
| acc_write | input | 1 | 1 = write, 0 = read |
| acc_ext | input | 1 | Extended (upper-half) access |
| acc_reg | input | 3 | Register code |
| acc_wdata | input | DW | Write data |
| acc_rdata | output | DW | Registered read data |
| busy | output | 1 | Search outstanding |
| srch_valid | output | 1 | Search request to lookup engine |
| srch_page | output | DW-PAGE_LSB | Page number searched |
| srch_done | input | 1 | Lookup result strobe |
| srch_hit | input | 1 | Lookup found an entry |
| srch_index | input | log2(ENTRIES) | Matching entry |
| pid_o | output | TID_W | Current process ID to lookup engine |
| zone_o | output | DW | Zone protection word to lookup engine |

## Verification
The assertions assume two things about the inputs. First, the lookup engine raises `srch_done` only while `srch_valid` is high. Second, the configuration inputs change only between requests. The bench follows both rules. It answers a search only after seeing `srch_valid`, and it changes `cfg_access` or `cfg_mmu_on` only when no request is driven. It drives requests one at a time and holds each for exactly one clock, so that the effect of every request is observed before the next one is issued.

// File: rtl/tlbreg_pkg.sv
package tlbreg_pkg;
    typedef enum logic [2:0] {
        RG_LO   = 3'd0,
        RG_HI   = 3'd1,
        RG_IDX  = 3'd2,
        RG_PID  = 3'd3,
        RG_ZONE = 3'd4,
        RG_SRCH = 3'd5
    } reg_code_e;

    typedef enum logic {
        S_IDLE = 1'b0,
        S_WAIT = 1'b1
    } srch_state_e;

    typedef struct packed {
        logic we_idx;
        logic we_hi;
        logic we_lo;
        logic we_pid;
        logic we_zone;
        logic start;
        logic re_idx;
        logic re_hi;
        logic re_lo;
        logic re_pid;
        logic re_zone;
    } dec_t;
endpackage

// File: rtl/tlbreg_decode.sv
module tlbreg_decode
    import tlbreg_pkg::*;
(
    input  logic       cfg_mmu_on,
    input  logic [1:0] cfg_access,
    input  logic       acc_valid,
    input  logic       acc_write,
    input  logic       acc_ext,
    input  logic [2:0] acc_reg,
    input  logic       busy,
    output dec_t       dec
);
    logic base_ok;
    logic priv_wr;
    logic rd_ok;
    logic ext_ok;

    always_comb begin
        base_ok = acc_valid && cfg_mmu_on && (cfg_access != 2'd0) && !busy;
        priv_wr = cfg_access[1];
        rd_ok   = cfg_access[0];
        ext_ok  = !acc_ext || (acc_reg == RG_LO);
        dec     = '0;
        if (base_ok && ext_ok) begin
            if (acc_write) begin
                case (acc_reg)
                    RG_IDX:  dec.we_idx  = 1'b1;
                    RG_HI:   dec.we_hi   = 1'b1;
                    RG_LO:   dec.we_lo   = 1'b1;
                    RG_PID:  dec.we_pid  = priv_wr;
                    RG_ZONE: dec.we_zone = priv_wr;
                    RG_SRCH: dec.start   = priv_wr;
                    default: dec         = '0;
                endcase
            end else begin
                case (acc_reg)
                    RG_IDX:  dec.re_idx  = 1'b1;
                    RG_HI:   dec.re_hi   = rd_ok;
                    RG_LO:   dec.re_lo   = rd_ok;
                    RG_PID:  dec.re_pid  = rd_ok;
                    RG_ZONE: dec.re_zone = rd_ok;
                    default: dec         = '0;
                endcase
            end
        end
    end
endmodule

// File: rtl/tlbreg_entries.sv
module tlbreg_entries #(
    parameter int ENTRIES = 16,
    parameter int DW      = 32,
    parameter int TID_W   = 8,
    localparam int IDX_W  = $clog2(ENTRIES)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [IDX_W-1:0]   sel,
    input  logic               hi_we,
    input  logic               lo_we,
    input  logic               lo_upper,
    input  logic [DW-1:0]      wdata,
    input  logic [TID_W-1:0]   tid_in,
    output logic [DW-1:0]      tag_rd,
    output logic [2*DW-1:0]    data_rd,
    output logic [TID_W-1:0]   tid_rd
);
    logic [DW-1:0]    tag_q  [ENTRIES];
    logic [2*DW-1:0]  data_q [ENTRIES];
    logic [TID_W-1:0] tid_q  [ENTRIES];

    for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
        logic hit_sel;
        assign hit_sel = (sel == IDX_W'(e));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                tag_q[e] <= '0;
                tid_q[e] <= '0;
            end else if (hi_we && hit_sel) begin
                tag_q[e] <= wdata;
                tid_q[e] <= tid_in;
            end
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                data_q[e] <= '0;
            end else if (lo_we && hit_sel) begin
                if (lo_upper) data_q[e][2*DW-1:DW] <= wdata;
                else          data_q[e][DW-1:0]    <= wdata;
            end
        end
    end

    assign tag_rd  = tag_q[sel];
    assign data_rd = data_q[sel];
    assign tid_rd  = tid_q[sel];
endmodule

// File: rtl/tlbreg_search_fsm.sv
module tlbreg_search_fsm
    import tlbreg_pkg::*;
#(
    parameter int PAGE_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [PAGE_W-1:0] page_in,
    input  logic              done,
    input  logic              hit,
    output logic              busy,
    output logic              req,
    output logic [PAGE_W-1:0] page_out,
    output logic              hit_upd,
    output logic              miss_upd
);
    srch_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE: if (start) state_d = S_WAIT;   // launch
            S_WAIT: if (done)  state_d = S_IDLE;   // resolve
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                           page_out <= '0;
        else if (state_q == S_IDLE && start)  page_out <= page_in;
    end

    always_comb begin
        busy     = 1'b0;
        req      = 1'b0;
        hit_upd  = 1'b0;
        miss_upd = 1'b0;
        unique case (state_q)
            S_IDLE: ;
            S_WAIT: begin
                busy     = 1'b1;
                req      = 1'b1;
                hit_upd  = done && hit;
                miss_upd = done && !hit;
            end
        endcase
    end
endmodule

// File: rtl/tlbreg_top.sv
module tlbreg_top
    import tlbreg_pkg::*;
#(
    parameter int ENTRIES  = 16,
    parameter int DW       = 32,
    parameter int TID_W    = 8,
    parameter int PAGE_LSB = 10,
    localparam int IDX_W   = $clog2(ENTRIES),
    localparam int PAGE_W  = DW - PAGE_LSB
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_mmu_on,
    input  logic [1:0]        cfg_access,
    input  logic              acc_valid,
    input  logic              acc_write,
    input  logic              acc_ext,
    input  logic [2:0]        acc_reg,
    input  logic [DW-1:0]     acc_wdata,
    output logic [DW-1:0]     acc_rdata,
    output logic              busy,
    output logic              srch_valid,
    output logic [PAGE_W-1:0] srch_page,
    input  logic              srch_done,
    input  logic              srch_hit,
    input  logic [IDX_W-1:0]  srch_index,
    output logic [TID_W-1:0]  pid_o,
    output logic [DW-1:0]     zone_o
);
    dec_t              dec;
    logic [DW-1:0]     tlbx_q;
    logic [DW-1:0]     pid_q;
    logic [DW-1:0]     zone_q;
    logic [DW-1:0]     rdata_q;
    logic [DW-1:0]     rd_val;
    logic [DW-1:0]     tag_rd;
    logic [2*DW-1:0]   data_rd;
    logic [TID_W-1:0]  tid_rd;
    logic              hit_upd;
    logic              miss_upd;

    tlbreg_decode u_dec (
        .cfg_mmu_on (cfg_mmu_on),
        .cfg_access (cfg_access),
        .acc_valid  (acc_valid),
        .acc_write  (acc_write),
        .acc_ext    (acc_ext),
        .acc_reg    (acc_reg),
        .busy       (busy),
        .dec        (dec)
    );

    tlbreg_entries #(.ENTRIES(ENTRIES), .DW(DW), .TID_W(TID_W)) u_ent (
        .clk      (clk),
        .rst_n    (rst_n),
        .sel      (tlbx_q[IDX_W-1:0]),
        .hi_we    (dec.we_hi),
        .lo_we    (dec.we_lo),
        .lo_upper (acc_ext),
        .wdata    (acc_wdata),
        .tid_in   (pid_q[TID_W-1:0]),
        .tag_rd   (tag_rd),
        .data_rd  (data_rd),
        .tid_rd   (tid_rd)
    );

    tlbreg_search_fsm #(.PAGE_W(PAGE_W)) u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (dec.start),
        .page_in  (acc_wdata[DW-1:PAGE_LSB]),
        .done     (srch_done),
        .hit      (srch_hit),
        .busy     (busy),
        .req      (srch_valid),
        .page_out (srch_page),
        .hit_upd  (hit_upd),
        .miss_upd (miss_upd)
    );

    // index register: lookup result outranks software (never coincident)
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tlbx_q <= '0;
        end else if (hit_upd) begin
            tlbx_q <= DW'(srch_index);
        end else if (miss_upd) begin
            tlbx_q[DW-1] <= 1'b1;
        end else if (dec.we_idx) begin
            tlbx_q[DW-2:0] <= acc_wdata[DW-2:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)          pid_q <= '0;
        else if (dec.re_hi)  pid_q <= DW'(tid_rd);
        else if (dec.we_pid) pid_q <= acc_wdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)           zone_q <= '0;
        else if (dec.we_zone) zone_q <= acc_wdata;
    end

    always_comb begin
        rd_val = '0;
        if (dec.re_idx)  rd_val = tlbx_q;
        if (dec.re_hi)   rd_val = tag_rd;
        if (dec.re_lo)   rd_val = acc_ext ? data_rd[2*DW-1:DW] : data_rd[DW-1:0];
        if (dec.re_pid)  rd_val = pid_q;
        if (dec.re_zone) rd_val = zone_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                       rdata_q <= '0;
        else if (acc_valid && !acc_write) rdata_q <= rd_val;
    end

    assign acc_rdata = rdata_q;
    assign pid_o     = pid_q[TID_W-1:0];
    assign zone_o    = zone_q;
endmodule

// File: rtl/tlbreg_check.sv
module tlbreg_check #(
    parameter int DW     = 32,
    parameter int IDX_W  = 4,
    parameter int PAGE_W = 22
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_mmu_on,
    input logic [1:0]        cfg_access,
    input logic              acc_valid,
    input logic              acc_write,
    input logic              acc_ext,
    input logic [2:0]        acc_reg,
    input logic [DW-1:0]     acc_rdata,
    input logic              busy,
    input logic              srch_done,
    input logic              srch_hit,
    input logic [IDX_W-1:0]  srch_index,
    input logic [PAGE_W-1:0] srch_page,
    input logic [DW-1:0]     zone_o,
    input logic [DW-1:0]     tlbx_q
);
    assert_hit_load_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && srch_done && srch_hit) |=> (tlbx_q == DW'($past(srch_index))));

    assert_miss_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && srch_done && !srch_hit) |=>
            (tlbx_q[DW-1] && tlbx_q[DW-2:0] == $past(tlbx_q[DW-2:0])));

    assert_launch_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(acc_valid && acc_write && acc_reg == 3'd5 && cfg_access[1]));

    assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(srch_page));

    assert_absent_read_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_valid && !acc_write && !cfg_mmu_on) |=> (acc_rdata == '0));

    assert_zone_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_access[1] || busy || acc_ext) |=> $stable(zone_o));

    assert_miss_bit_ro_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && acc_valid && acc_write && acc_reg == 3'd2) |=>
            (tlbx_q[DW-1] == $past(tlbx_q[DW-1])));
endmodule

bind tlbreg_top tlbreg_check #(.DW(DW), .IDX_W(IDX_W), .PAGE_W(PAGE_W)) u_check (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfg_mmu_on (cfg_mmu_on),
    .cfg_access (cfg_access),
    .acc_valid  (acc_valid),
    .acc_write  (acc_write),
    .acc_ext    (acc_ext),
    .acc_reg    (acc_reg),
    .acc_rdata  (acc_rdata),
    .busy       (busy),
    .srch_done  (srch_done),
    .srch_hit   (srch_hit),
    .srch_index (srch_index),
    .srch_page  (srch_page),
    .zone_o     (zone_o),
    .tlbx_q     (tlbx_q)
);

// File: tb/tlbreg_top_test.sv
module tlbreg_top_test;
    localparam int ENTRIES = 16;
    localparam int DW      = 32;
    localparam int IDX_W   = 4;
    localparam int PAGE_W  = 22;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              cfg_mmu_on = 1'b1;
    logic [1:0]        cfg_access = 2'd3;
    logic              acc_valid = 1'b0;
    logic              acc_write = 1'b0;
    logic              acc_ext = 1'b0;
    logic [2:0]        acc_reg = 3'd0;
    logic [DW-1:0]     acc_wdata = '0;
    logic [DW-1:0]     acc_rdata;
    logic              busy;
    logic              srch_valid;
    logic [PAGE_W-1:0] srch_page;
    logic              srch_done = 1'b0;
    logic              srch_hit = 1'b0;
    logic [IDX_W-1:0]  srch_index = '0;
    logic [7:0]        pid_o;
    logic [DW-1:0]     zone_o;

    int errors = 0;
    int checks = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    tlbreg_top uut (.*);

    task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(logic [2:0] rg, logic ext, logic [DW-1:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b1; acc_ext = ext; acc_reg = rg; acc_wdata = d;
        @(negedge clk);
        acc_valid = 1'b0; acc_write = 1'b0; acc_ext = 1'b0;
    endtask

    task automatic rd(logic [2:0] rg, logic ext, output logic [DW-1:0] d);
        @(negedge clk);
        acc_valid = 1'b1; acc_write = 1'b0; acc_ext = ext; acc_reg = rg;
        @(negedge clk);
        d = acc_rdata;
        acc_valid = 1'b0; acc_ext = 1'b0;
    endtask

    task automatic respond(logic h, logic [IDX_W-1:0] ix);
        srch_done = 1'b1; srch_hit = h; srch_index = ix;
        @(negedge clk);
        srch_done = 1'b0; srch_hit = 1'b0;
    endtask

    function automatic logic [DW-1:0] tagv(int e);
        return 32'hA000_0001 | (DW'(e) << 12) | (DW'(e) << 1);
    endfunction

    initial begin
        #(5.0 * 100000);
        if (!finished) begin
            errors++; checks++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 rdata", acc_rdata, '0);
        check("R1 busy", {31'd0, busy}, 0);
        check("R1 pid", {24'd0, pid_o}, 0);
        check("R1 zone", zone_o, '0);
        rd(3'd2, 0, v); check("R1 index", v, '0);

        // R3 fill every entry
        for (int e = 0; e < ENTRIES; e++) begin
            wr(3'd2, 0, DW'(e));
            wr(3'd3, 0, DW'(e + 'h40));
            wr(3'd1, 0, tagv(e));
            wr(3'd0, 0, ~tagv(e));
            wr(3'd0, 1, DW'(e * 3 + 7));
        end
        wr(3'd3, 0, '0);
        // R4/R5 read back every entry
        for (int e = 0; e < ENTRIES; e++) begin
            wr(3'd2, 0, DW'(e));
            rd(3'd1, 0, v); check("R3 tag", v, tagv(e));
            check("R4 pid from tid", {24'd0, pid_o}, DW'(e + 'h40));
            rd(3'd0, 0, v); check("R3 data low", v, ~tagv(e));
            rd(3'd0, 1, v); check("R5 data high", v, DW'(e * 3 + 7));
            rd(3'd2, 0, v); check("R2 index", v, DW'(e));
        end

        // R2 bit 31 not writable; low bits pick entry
        wr(3'd2, 0, 32'hFFFF_FFFF);
        rd(3'd2, 0, v); check("R2 bit31 ro", v, 32'h7FFF_FFFF);
        rd(3'd1, 0, v); check("R2 low bits select", v, tagv(15));

        // R5 extended access elsewhere
        wr(3'd3, 0, 32'h12);
        wr(3'd3, 1, 32'h55);
        check("R5 ext pid write", {24'd0, pid_o}, 32'h12);
        wr(3'd4, 0, 32'hCAFE_0001);
        rd(3'd4, 1, v); check("R5 ext zone read", v, '0);
        wr(3'd1, 1, 32'h1);
        rd(3'd1, 0, v); check("R5 ext hi write", v, tagv(15));

        // R6/R7/R8 sweep access levels
        for (int a = 0; a < 4; a++) begin
            cfg_access = 2'd3;
            wr(3'd3, 0, 32'h11); wr(3'd4, 0, 32'h22); wr(3'd2, 0, 32'h5);
            cfg_access = 2'(a);
            wr(3'd3, 0, 32'h33); wr(3'd4, 0, 32'h44);
            check("R6 pid gate", {24'd0, pid_o}, (a >= 2) ? 32'h33 : 32'h11);
            check("R6 zone gate", zone_o, (a >= 2) ? 32'h44 : 32'h22);
            rd(3'd4, 0, v);
            check("R7 zone read gate", v, (a % 2 == 1) ? zone_o : '0);
            wr(3'd2, 0, 32'h6);
            rd(3'd2, 0, v);
            check("R8 index at level", v, (a == 0) ? 32'h0 : 32'h6);
            rd(3'd1, 0, v);
            check("R7 hi read gate", v, (a % 2 == 1) ? tagv(a == 0 ? 5 : 6) : '0);
            check("R7 no pid side effect", {24'd0, pid_o},
                  (a % 2 == 1) ? DW'(6 + 'h40) : ((a >= 2) ? 32'h33 : 32'h11));
        end
        cfg_access = 2'd3;
        wr(3'd2, 0, 32'h5);
        cfg_mmu_on = 1'b0;
        wr(3'd2, 0, 32'h9);
        rd(3'd2, 0, v); check("R8 absent read", v, '0);
        cfg_mmu_on = 1'b1;
        rd(3'd2, 0, v); check("R8 absent write", v, 32'h5);

        // R9/R12/R10 search hit
        wr(3'd5, 0, 32'h1234_5678);
        check("R9 busy", {31'd0, busy}, 1);
        check("R9 srch_valid", {31'd0, srch_valid}, 1);
        check("R9 page", DW'(srch_page), 32'h1234_5678 >> 10);
        wr(3'd2, 0, 32'h3);
        rd(3'd2, 0, v); check("R12 read while busy", v, '0);
        respond(1'b1, 4'd9);
        check("R10 busy drop", {31'd0, busy}, 0);
        rd(3'd2, 0, v); check("R10 hit index", v, 32'h9);

        // R10 miss, then R2 flag survives writes, hit clears it
        wr(3'd2, 0, 32'h7);
        wr(3'd5, 0, 32'hFFFF_FC00);
        check("R9 page high", DW'(srch_page), 32'h003F_FFFF);
        respond(1'b0, 4'd2);
        rd(3'd2, 0, v); check("R10 miss flag", v, 32'h8000_0007);
        wr(3'd2, 0, 32'h2);
        rd(3'd2, 0, v); check("R2 flag kept", v, 32'h8000_0002);
        wr(3'd5, 0, 32'h0);
        respond(1'b1, 4'd4);
        rd(3'd2, 0, v); check("R10 hit clears flag", v, 32'h4);

        // R6 search needs level 2+
        cfg_access = 2'd1;
        wr(3'd5, 0, 32'h0);
        check("R6 search gated", {31'd0, busy}, 0);
        cfg_access = 2'd3;

        // R11 search/unused codes read zero, writes inert
        rd(3'd2, 0, v);
        rd(3'd5, 0, v); check("R11 search reads zero", v, '0);
        wr(3'd6, 0, 32'hFFFF_FFFF);
        wr(3'd7, 0, 32'hFFFF_FFFF);
        rd(3'd7, 0, v); check("R11 unused read", v, '0);
        rd(3'd2, 0, v); check("R11 unused write inert", v, 32'h4);
        check("R11 zone untouched", zone_o, 32'h44);

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule